// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical address for a segmented memory model. It keeps six segment registers: code, data, stack and three extra data segments. A write port loads them. Each cycle a request comes in with an access kind and an offset, and may carry a segment override. The block picks the segment, multiplies its paragraph number by sixteen, adds the offset and presents the result one clock later.

Instruction fetches always take the code segment. Stack accesses and accesses to parameters through the base pointer default to the stack segment. Ordinary data accesses default to the data segment. An override can replace the default for any access kind except an instruction fetch.

Top module: `seg_addr_gen`

## Requirements
- R1: After a synchronous active-high reset, every segment register holds 0x0000 except the code segment, which holds 0xFFFF. `addr_valid` is 0 and `phys_addr` is 0.
- R2: The physical address equals (segment << 4) + offset, truncated to 20 bits, so a sum past 0xFFFFF wraps around.
- R3: An accepted request (`req_valid`=1) produces `addr_valid`=1 and its `phys_addr` exactly one cycle later. With `req_valid`=0, `addr_valid` is 0 in the next cycle.
- R4: Access kind 0 (instruction fetch) uses the code segment, and any override is ignored.
- R5: Access kind 1 (data) uses the data segment when no override is present.
- R6: Access kinds 2 (stack) and 3 (base-pointer parameter) use the stack segment when no override is present.
- R7: When `ovr_valid`=1 and the access is not a fetch, the segment register selected by `ovr_sel` is used. The selector codes are 0=code, 1=data, 2=stack, 3=extra0, 4=extra1, 5=extra2.
- R8: `wr_en`=1 loads `wr_data` into the register selected by `wr_sel` (same codes as R7). A request in the following cycle sees the new value. An `ovr_sel`/`wr_sel` code of 6 or 7 writes nothing and selects a segment value of 0.
- R9: A write to one segment register leaves every other segment register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | segment register write strobe |
| wr_sel | input | 3 | segment register written |
| wr_data | input | 16 | paragraph value written |
| req_valid | input | 1 | address request present |
| req_kind | input | 2 | access kind: 0 fetch, 1 data, 2 stack, 3 base-pointer parameter |
| req_offset | input | 16 | offset inside the segment |
| ovr_valid | input | 1 | segment override present |
| ovr_sel | input | 3 | segment register named by the override |
| addr_valid | output | 1 | phys_addr holds a result |
| phys_addr | output | 20 | physical address |

## Verification
The bench checks the wraparound past 1 MiB using the code segment's reset value 0xFFFF with large offsets. A design that dropped the carry or widened the sum would return the wrong address. It sends a fetch with an override and checks that the code segment is still used; a design that honoured the override would address the data or extra segment. Stack and parameter requests go to the stack segment, and each extra segment is loaded with its own distinct value. That way a swapped default or a mis-decoded selector gives a visibly different address. A write directly followed by a request checks that the new value is used, not the stale one.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_W  = 16;
  localparam int OFF_W  = 16;
  localparam int PA_W   = 20;
  localparam int SHIFT  = 4;
  localparam int NSEG   = 6;
  localparam int SEL_W  = 3;

  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_DATA  = 2'd1,
    K_STACK = 2'd2,
    K_PARAM = 2'd3
  } kind_e;

  typedef enum logic [SEL_W-1:0] {
    S_CODE = 3'd0,
    S_DATA = 3'd1,
    S_STK  = 3'd2,
    S_X0   = 3'd3,
    S_X1   = 3'd4,
    S_X2   = 3'd5
  } seg_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int SEG_W = 16,
  parameter int NSEG  = 6,
  parameter int SEL_W = 3,
  parameter logic [SEG_W-1:0] CODE_RST = '1,
  parameter int CODE_IDX = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [SEG_W-1:0] rd_data
);
  logic [SEG_W-1:0] regs [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_reg
    localparam logic [SEG_W-1:0] RV = (g == CODE_IDX) ? CODE_RST : '0;
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= RV;
      else if (wr_en && (int'(wr_sel) == g))
        regs[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSEG; i++)
      if (int'(rd_sel) == i) rd_data = regs[i];
  end
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
(
  input  logic [1:0]       kind,
  input  logic             ovr_valid,
  input  logic [SEL_W-1:0] ovr_sel,
  output logic [SEL_W-1:0] sel
);
  always_comb begin
    unique case (kind_e'(kind))
      K_FETCH: sel = S_CODE;
      K_DATA:  sel = S_DATA;
      K_STACK, K_PARAM: sel = S_STK;
      default: sel = S_DATA;
    endcase
    if (ovr_valid && kind_e'(kind) != K_FETCH)
      sel = ovr_sel;
  end
endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int PA_W  = 20,
  parameter int SHIFT = 4
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  pa
);
  localparam int SUM_W = SEG_W + SHIFT + 1;
  logic [SUM_W-1:0] base, ext, sum;
  always_comb begin
    base = SUM_W'({seg, {SHIFT{1'b0}}});
    ext  = SUM_W'(off);
    sum  = base + ext;
    pa   = sum[PA_W-1:0];
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [15:0]      wr_data,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [15:0]      req_offset,
  input  logic             ovr_valid,
  input  logic [2:0]       ovr_sel,
  output logic             addr_valid,
  output logic [19:0]      phys_addr
);
  logic [SEL_W-1:0] sel;
  logic [SEG_W-1:0] seg_val;
  logic [PA_W-1:0]  pa_next;

  seg_select u_sel (
    .kind(req_kind), .ovr_valid(ovr_valid), .ovr_sel(ovr_sel), .sel(sel)
  );

  seg_regfile #(
    .SEG_W(SEG_W), .NSEG(NSEG), .SEL_W(SEL_W),
    .CODE_RST('1), .CODE_IDX(int'(S_CODE))
  ) u_rf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(sel), .rd_data(seg_val)
  );

  addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .SHIFT(SHIFT)) u_add (
    .seg(seg_val), .off(req_offset), .pa(pa_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      phys_addr  <= '0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid) phys_addr <= pa_next;
    end
  end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [1:0]  req_kind,
  input logic        ovr_valid,
  input logic        addr_valid,
  input logic [19:0] phys_addr,
  input logic [2:0]  sel
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> addr_valid); // R3
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !addr_valid); // R3
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(phys_addr)); // R3
  AST_FETCH_CODE: assert property (@(posedge clk) disable iff (rst)
    (req_kind == 2'd0) |-> (sel == 3'd0)); // R4
  AST_STACK_DEF: assert property (@(posedge clk) disable iff (rst)
    (req_kind[1] && !ovr_valid) |-> (sel == 3'd2)); // R6
  AST_DATA_DEF: assert property (@(posedge clk) disable iff (rst)
    (req_kind == 2'd1 && !ovr_valid) |-> (sel == 3'd1)); // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !addr_valid); // R1
endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
  .ovr_valid(ovr_valid), .addr_valid(addr_valid), .phys_addr(phys_addr),
  .sel(sel)
);

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb_top;
  localparam time CLK_PERIOD = 10ns;
  logic clk = 0, rst = 1;
  logic wr_en = 0; logic [2:0] wr_sel = 0; logic [15:0] wr_data = 0;
  logic req_valid = 0; logic [1:0] req_kind = 0; logic [15:0] req_offset = 0;
  logic ovr_valid = 0; logic [2:0] ovr_sel = 0;
  logic addr_valid; logic [19:0] phys_addr;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_gen dut_i (.*);

  function automatic logic [19:0] exp_pa(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] t;
    t = {1'b0, s, 4'h0} + {5'h0, o};
    return t[19:0];
  endfunction

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_seg(input logic [2:0] s, input logic [15:0] v);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic request(input logic [1:0] k, input logic [15:0] o,
                         input logic ov, input logic [2:0] os,
                         input string req, input logic [19:0] exp);
    @(negedge clk); req_valid = 1; req_kind = k; req_offset = o; ovr_valid = ov; ovr_sel = os;
    @(negedge clk); req_valid = 0; ovr_valid = 0;
    check(req, {19'd0, addr_valid}, 20'd1);
    check(req, phys_addr, exp);
  endtask

  task automatic t_reset;
    check("R1 valid", {19'd0, addr_valid}, 0);
    check("R1 addr", phys_addr, 0);
    request(2'd0, 16'h0000, 0, 0, "R1 code reset", 20'hFFFF0);
    request(2'd1, 16'h0012, 0, 0, "R1 data reset", 20'h00012);
    request(2'd2, 16'h0034, 0, 0, "R1 stack reset", 20'h00034);
  endtask

  task automatic t_wrap;
    request(2'd0, 16'h0010, 0, 0, "R2 wrap", exp_pa(16'hFFFF, 16'h0010));
    request(2'd0, 16'hFFFF, 0, 0, "R2 wrap max", 20'h0FFEF);
  endtask

  task automatic t_defaults;
    write_seg(3'd0, 16'h1000);
    write_seg(3'd1, 16'h2000);
    write_seg(3'd2, 16'h3000);
    write_seg(3'd3, 16'h4000);
    write_seg(3'd4, 16'h5000);
    write_seg(3'd5, 16'h6000);
    request(2'd0, 16'h0123, 0, 0, "R4 fetch", exp_pa(16'h1000, 16'h0123));
    request(2'd1, 16'h0456, 0, 0, "R5 data", exp_pa(16'h2000, 16'h0456));
    request(2'd2, 16'h0789, 0, 0, "R6 stack", exp_pa(16'h3000, 16'h0789));
    request(2'd3, 16'h0abc, 0, 0, "R6 param", exp_pa(16'h3000, 16'h0abc));
  endtask

  task automatic t_override;
    request(2'd0, 16'h0001, 1, 3'd3, "R4 fetch ignores ovr", exp_pa(16'h1000, 16'h0001));
    request(2'd1, 16'h0002, 1, 3'd3, "R7 ovr x0", exp_pa(16'h4000, 16'h0002));
    request(2'd2, 16'h0003, 1, 3'd4, "R7 ovr x1", exp_pa(16'h5000, 16'h0003));
    request(2'd3, 16'h0004, 1, 3'd5, "R7 ovr x2", exp_pa(16'h6000, 16'h0004));
    request(2'd1, 16'h0005, 1, 3'd0, "R7 ovr code", exp_pa(16'h1000, 16'h0005));
    request(2'd1, 16'h0006, 1, 3'd7, "R8 bad sel", exp_pa(16'h0000, 16'h0006));
  endtask

  task automatic t_write_then_use;
    @(negedge clk); wr_en = 1; wr_sel = 3'd1; wr_data = 16'hABCD;
    @(negedge clk); wr_en = 0;
    req_valid = 1; req_kind = 2'd1; req_offset = 16'h0010; ovr_valid = 0;
    @(negedge clk); req_valid = 0;
    check("R8 new value", phys_addr, exp_pa(16'hABCD, 16'h0010));
    write_seg(3'd6, 16'h7777);
    request(2'd2, 16'h0000, 0, 0, "R9 stack kept", 20'h30000);
    request(2'd1, 16'h0000, 1, 3'd4, "R9 x1 kept", 20'h50000);
    request(2'd0, 16'h0000, 0, 0, "R9 code kept", 20'h10000);
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R3 idle", {19'd0, addr_valid}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset; t_wrap; t_defaults; t_override; t_write_then_use; t_idle;
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule